// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block derives a periodic interrupt event from a 32.768 kHz tick enable. A 4-bit rate code picks a power-of-two period: code N gives 2^(N-1) ticks. Code 0 stops the events, and so does a low enable input. A free-running 15-bit tick counter keeps the phase. Events fall on absolute multiples of the period in that counter, not on a period measured from the moment the block was enabled or the rate was changed.

Each event is a one-cycle pulse. It comes with an 8-bit flag-set mask for the adjacent status register, which raises the periodic flag and the interrupt-request flag. Rate and enable are read live on every tick. A new setting therefore applies from the next tick without a reset, and the next event falls on the next boundary of the new period.

Top module: `rtc_periodic_divider`

## Requirements
- R1: While rst_ni is low and after its release, evt_o is 0, flag_set_o is 0 and the tick counter is 0.
- R2: With rate code N (1..15) and enable high, events are 2^(N-1) ticks apart. Code 1 fires on every tick and code 2 on every other tick.
- R3: Rate code 0 produces no event, whatever the tick or enable inputs.
- R4: With en_i low no event occurs. The tick counter keeps counting while disabled.
- R5: An event occurs on a tick that takes the counter to a value whose low N-1 bits are all zero, so events align with absolute multiples of the period.
- R6: evt_o is high for exactly the one clock cycle after an edge at which tick_i was sampled high and the R5 condition held. Without a tick there is no event.
- R7: flag_set_o is 8'hC0 (bit 7 interrupt request, bit 6 periodic flag) in the cycle evt_o is high, and 8'h00 otherwise.
- R8: A change of rate_i or en_i takes effect at the next tick with no reset. The next event is the next boundary of the new period, computed from the same counter.
- R9: The tick counter is 15 bits wide, advances by one on each tick and wraps from 32767 to 0. The wrap is a boundary for every rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle per tick |
| rate_i | input | 4 | Rate code; 0 stops events, N gives 2^(N-1) ticks |
| en_i | input | 1 | Periodic interrupt enable |
| evt_o | output | 1 | One-cycle periodic event pulse |
| flag_set_o | output | 8 | Flag bits to OR into the status register during an event |

## Verification
Every rate code from 0 to 15 runs with a tick on every cycle for at least two full periods. This shows that each code picks its own period and that the counter wrap counts as a boundary. Codes 1 to 6 then run with a tick on every third cycle, which separates counting ticks from counting clock cycles. Two further runs hold en_i low and then change the rate in mid-period; they show that events follow absolute counter boundaries rather than the moment of the change. The expected pulse comes each cycle from an arithmetic tick-count model in the bench.

// File: rtl/rtc_pdiv_pkg.sv
package rtc_pdiv_pkg;
  localparam int unsigned CNT_W  = 15;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned IRQ_BIT = 7;
  localparam int unsigned PER_BIT = 6;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [FLAG_W-1:0] flag_t;
endpackage

// File: rtl/rtc_pdiv_counter.sv
module rtc_pdiv_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o = cnt_q + CNT_W'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_pdiv_rate_decode.sv
module rtc_pdiv_rate_decode #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic              en_i,
  output logic [CNT_W-1:0]  mask_o,
  output logic              active_o
);
  // mask = 2^(code-1)-1: bit b set when code >= b+2
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask_o[b] = (32'(rate_i) >= (b + 2));
  end

  assign active_o = en_i && (rate_i != '0);
endmodule

// File: rtl/rtc_pdiv_boundary.sv
module rtc_pdiv_boundary #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             evt_o
);
  logic hit;
  logic evt_q;

  assign hit = tick_i && active_i && ((nxt_i & mask_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= hit;
  end

  assign evt_o = evt_q;

  // R6
  evt_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(tick_i));
  // R4
  evt_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(active_i));
endmodule

// File: rtl/rtc_periodic_divider.sv
module rtc_periodic_divider
  import rtc_pdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              en_i,
  output logic              evt_o,
  output logic [FLAG_W-1:0] flag_set_o
);
  cnt_t cnt, nxt, mask;
  logic active;

  rtc_pdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt),
    .nxt_o (nxt)
  );

  rtc_pdiv_rate_decode #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_dec (
    .rate_i  (rate_i),
    .en_i    (en_i),
    .mask_o  (mask),
    .active_o(active)
  );

  rtc_pdiv_boundary #(.CNT_W(CNT_W)) u_bnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .active_i(active),
    .mask_i  (mask),
    .nxt_i   (nxt),
    .evt_o   (evt_o)
  );

  always_comb begin
    flag_set_o = '0;
    flag_set_o[IRQ_BIT] = evt_o;
    flag_set_o[PER_BIT] = evt_o;
  end

  // R5
  evt_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (cnt & $past(mask)) == '0);
  // R3
  evt_zero_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(rate_i) != '0);
  // R7
  flag_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flag_set_o) == (evt_o ? 2 : 0));
endmodule

// File: tb/rtc_periodic_divider_test.sv
`timescale 1ns/1ps
module rtc_periodic_divider_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] rate_i = 4'd0;
  logic       en_i = 1'b0;
  logic       evt_o;
  logic [7:0] flag_set_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned model_cnt = 0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  rtc_periodic_divider uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rate_i(rate_i),
    .en_i(en_i), .evt_o(evt_o), .flag_set_o(flag_set_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one clock cycle: drive at negedge, check at following negedge
  task automatic step(input bit t, input int code, input bit en, input string req);
    bit exp;
    int unsigned nxt;
    tick_i = t; rate_i = 4'(code); en_i = en;
    nxt = (model_cnt + 1) % 32768;
    exp = t && en && code != 0 && ((nxt % (1 << (code > 0 ? code - 1 : 0))) == 0);
    @(posedge clk_i);
    if (t) model_cnt = nxt;
    @(negedge clk_i);
    check(evt_o == exp, req, int'(evt_o), int'(exp));
    check(flag_set_o == (exp ? 8'hC0 : 8'h00), "R7", int'(flag_set_o), exp ? 'hC0 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(evt_o == 1'b0, "R1", int'(evt_o), 0);
    check(flag_set_o == 8'h00, "R1", int'(flag_set_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: counter at 0 -> code 1 fires on first tick, code 2 on second
    step(1'b1, 1, 1'b1, "R1");
    step(1'b1, 2, 1'b1, "R1");
    // R3: code 0 with ticks and enable
    for (int i = 0; i < 100; i++) step(1'b1, 0, 1'b1, "R3");
    // R4: disabled, counter keeps running
    for (int i = 0; i < 100; i++) step(1'b1, 3, 1'b0, "R4");
    // R6: no tick, no event
    for (int i = 0; i < 20; i++) step(1'b0, 1, 1'b1, "R6");
    // R2 / R5 / R9: every code, continuous ticks, >= two periods; wraps occur
    for (int c = 1; c < 16; c++)
      for (int i = 0; i < (1 << c) + 10; i++) step(1'b1, c, 1'b1, "R2");
    // R6: sparse ticks (every third cycle)
    for (int c = 1; c < 7; c++)
      for (int i = 0; i < 200; i++) step((i % 3) == 0, c, 1'b1, "R6");
    // R8: mid-period rate and enable changes
    for (int i = 0; i < 700; i++) step(1'b1, 10, 1'b1, "R8");
    for (int i = 0; i < 50; i++)  step(1'b1, 3, 1'b1, "R8");
    for (int i = 0; i < 13; i++)  step(1'b1, 5, 1'b0, "R8");
    for (int i = 0; i < 100; i++) step(1'b1, 5, 1'b1, "R5");
    finish_run();
  end
endmodule